// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one programmable output cell placed between a sum-of-products array and a bidirectional pad. It receives a vector of product terms from the array, two mode bits shared by every cell of the device, and three configuration bits of its own. From these it forms a logic level for the pad, decides whether the pad driver is on, and returns a feedback bit to the array.

The shared mode bits choose among a clocked mode, a mixed mode and a plain mode. Within them the per-cell bits pick a registered output, a combinational I/O whose enable comes from one product term, an always-driven combinational output or a pure input. A polarity bit chooses active-high or active-low output, and a drive bit chooses push-pull or open-drain drive. The state register can be cleared by a synchronous active-low reset and loaded with any value through a preload path for test.

Top module: `pterm_out_cell`

## Requirements
- R1: The mode pair {glb_sync, glb_arch} decodes as 01 = clocked, 11 = mixed, 10 = plain. The unused pair 00 leaves the driver off (pad_oe = 0) and returns pad_in on fb_out.
- R2: In clocked mode with cell_io_sel = 0, each rising clk edge (reset high, preload low) captures the OR of all product terms. The pad level after that edge is the OR for cell_polarity = 1 and its inverse for cell_polarity = 0. pad_oe follows the inverse of oe_pin_n without a clock.
- R3: In clocked mode with cell_io_sel = 1, and in mixed mode, pad_out is the OR of pt_in[NUM_PT-1:1] after polarity, and pt_in[0] alone enables the driver.
- R4: In mixed mode cell_io_sel has no effect on any output.
- R5: In plain mode with cell_io_sel = 0, pad_out is the OR of all product terms after polarity, and the push-pull driver is always enabled.
- R6: In plain mode with cell_io_sel = 1, the driver is off and fb_out carries pad_in.
- R7: Flipping cell_polarity inverts pad_out in every combinational configuration.
- R8: With cell_push_pull = 0 the driver is enabled only while pad_out is 0 and the enable source is active. A high level releases the pad.
- R9: When preload_en is high at a rising clk edge with reset high, the register takes preload_val, and the registered pad level becomes the inverse of preload_val.
- R10: Preload takes priority over the captured product-term value on the same edge.
- R11: rst_n low at a rising edge clears the register. A registered cell then shows pad_out = 1 for either polarity.
- R12: A registered cell returns its registered pad level on fb_out even while oe_pin_n disables the driver. Every other configuration returns pad_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared register clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| pt_in | input | NUM_PT | Product terms from the array; bit 0 can serve as the enable term |
| glb_sync | input | 1 | Global mode bit, high for mixed and plain modes |
| glb_arch | input | 1 | Global mode bit, high for clocked and mixed modes |
| cell_io_sel | input | 1 | Per-cell select: combinational I/O or input instead of the default function |
| cell_push_pull | input | 1 | 1 = push-pull drive, 0 = open-drain |
| cell_polarity | input | 1 | 1 = active-high output, 0 = active-low |
| oe_pin_n | input | 1 | Shared active-low enable for registered cells |
| preload_en | input | 1 | Loads preload_val into the register at the next edge |
| preload_val | input | 1 | Value forced into the register |
| pad_in | input | 1 | Level read back from the pad |
| pad_out | output | 1 | Cell logic level offered to the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback bit returned to the array |

## Verification
The bench builds the cell with NUM_PT = 8, the default. With that value one enable term and seven data terms are both reachable, so single-term patterns show which term feeds the sum and which feeds the enable. Random words over all mode and configuration bits reach every decode corner. Preload and reset pulses are scattered among them, and directed patterns cover the cases where the enable-term path and the full-sum path give different results.

// File: rtl/cellcfg_pkg.sv
// Shared types for the output macrocell: mode encoding, enable source
// and the decoded control word passed from the decoder to the datapath.
package cellcfg_pkg;

    // Mode pair {glb_sync, glb_arch}
    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_CLOCK  = 2'b01,
        MODE_PLAIN  = 2'b10,
        MODE_MIXED  = 2'b11
    } glb_mode_e;

    // Source of the pad driver enable
    typedef enum logic [1:0] {
        EN_NONE   = 2'b00,
        EN_ALWAYS = 2'b01,
        EN_PIN    = 2'b10,
        EN_TERM   = 2'b11
    } en_src_e;

    typedef struct packed {
        logic    use_reg;   // pad level comes from the register
        logic    oe_term;   // enable term removed from the data sum
        en_src_e en_src;    // where the driver enable comes from
    } cell_ctl_t;

endpackage

// File: rtl/cell_mode_decode.sv
// Decodes the global mode pair and the per-cell select bit into the
// control word. Purely combinational; assumes bits are static in use.
module cell_mode_decode
    import cellcfg_pkg::*;
(
    input  logic      glb_sync,
    input  logic      glb_arch,
    input  logic      cell_io_sel,
    output cell_ctl_t ctl
);

    glb_mode_e mode;

    // Form the mode from the two global bits
    always_comb mode = glb_mode_e'({glb_sync, glb_arch});

    // Map mode and cell select to register use, term use and enable source
    always_comb begin
        ctl = '{use_reg: 1'b0, oe_term: 1'b0, en_src: EN_NONE};
        unique case (mode)
            MODE_CLOCK: begin
                ctl.use_reg = !cell_io_sel;
                ctl.oe_term = cell_io_sel;
                ctl.en_src  = cell_io_sel ? EN_TERM : EN_PIN;
            end
            MODE_MIXED: begin
                ctl.oe_term = 1'b1;
                ctl.en_src  = EN_TERM;
            end
            MODE_PLAIN: begin
                ctl.en_src  = cell_io_sel ? EN_NONE : EN_ALWAYS;
            end
            default: begin
                ctl.en_src  = EN_NONE;
            end
        endcase
    end

endmodule

// File: rtl/cell_term_sum.sv
// Forms the OR of product terms. The full sum always feeds the register;
// the selected sum drops the enable term when it is reserved for OE.
module cell_term_sum #(
    parameter int NUM_PT = 8
) (
    input  logic [NUM_PT-1:0] pt_in,
    input  logic              oe_term,
    output logic              sum_all,
    output logic              sum_sel,
    output logic              term_en
);

    localparam int OE_IDX = 0;
    localparam int DATA_LO = OE_IDX + 1;

    logic [NUM_PT-1:0] data_mask;

    // Mask that clears the enable term from the data sum
    generate
        for (genvar i = 0; i < NUM_PT; i++) begin : g_mask
            if (i < DATA_LO) begin : g_oe
                assign data_mask[i] = 1'b0;
            end else begin : g_data
                assign data_mask[i] = 1'b1;
            end
        end
    endgenerate

    // Sum all terms, and sum data terms only
    always_comb begin
        sum_all = |pt_in;
        sum_sel = oe_term ? |(pt_in & data_mask) : sum_all;
        term_en = pt_in[OE_IDX];
    end

endmodule

// File: rtl/cell_state_reg.sv
// Cell state register: synchronous active-low clear, then preload,
// then capture of the polarity-adjusted full sum. The pad level of a
// registered cell is the inverse of q, so a cleared register reads high.
module cell_state_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic sum_all,
    input  logic polarity,
    input  logic preload_en,
    input  logic preload_val,
    output logic q
);

    logic d_next;

    // Store the inverse of the wanted pad level
    always_comb d_next = polarity ? !sum_all : sum_all;

    // Register update: reset over preload over capture
    always_ff @(posedge clk) begin
        if (!rst_n)          q <= 1'b0;
        else if (preload_en) q <= preload_val;
        else                 q <= d_next;
    end

    assert_preload_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(preload_en)) |-> (q == $past(preload_val)));

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(preload_en)) |-> (q == ($past(sum_all) ^ $past(polarity))));

    assert_reset_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (q == 1'b0));

endmodule

// File: rtl/cell_pad_drive.sv
// Chooses the pad level, the driver enable and the feedback bit from the
// control word. Open-drain drive is enabled only for a low level.
module cell_pad_drive
    import cellcfg_pkg::*;
(
    input  cell_ctl_t ctl,
    input  logic      sum_sel,
    input  logic      term_en,
    input  logic      q,
    input  logic      polarity,
    input  logic      push_pull,
    input  logic      oe_pin_n,
    input  logic      pad_in,
    output logic      pad_out,
    output logic      pad_oe,
    output logic      fb_out
);

    logic lvl_comb;
    logic lvl_reg;
    logic en_raw;

    // Candidate levels from the combinational and registered paths
    always_comb begin
        lvl_comb = polarity ? sum_sel : !sum_sel;
        lvl_reg  = !q;
    end

    // Driver enable source selection
    always_comb begin
        unique case (ctl.en_src)
            EN_ALWAYS: en_raw = 1'b1;
            EN_PIN:    en_raw = !oe_pin_n;
            EN_TERM:   en_raw = term_en;
            default:   en_raw = 1'b0;
        endcase
    end

    // Pad level, drive type and feedback
    always_comb begin
        pad_out = ctl.use_reg ? lvl_reg : lvl_comb;
        pad_oe  = en_raw && (push_pull || !pad_out);
        fb_out  = ctl.use_reg ? lvl_reg : pad_in;
    end

endmodule

// File: rtl/pterm_out_cell.sv
// Top of the output macrocell: decoder, term sum, state register and pad
// drive. Assumes configuration bits are held static while in use.
module pterm_out_cell
    import cellcfg_pkg::*;
#(
    parameter int NUM_PT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PT-1:0] pt_in,
    input  logic              glb_sync,
    input  logic              glb_arch,
    input  logic              cell_io_sel,
    input  logic              cell_push_pull,
    input  logic              cell_polarity,
    input  logic              oe_pin_n,
    input  logic              preload_en,
    input  logic              preload_val,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              fb_out
);

    cell_ctl_t ctl;
    logic      sum_all;
    logic      sum_sel;
    logic      term_en;
    logic      q;

    cell_mode_decode u_decode (
        .glb_sync    (glb_sync),
        .glb_arch    (glb_arch),
        .cell_io_sel (cell_io_sel),
        .ctl         (ctl)
    );

    cell_term_sum #(.NUM_PT(NUM_PT)) u_sum (
        .pt_in   (pt_in),
        .oe_term (ctl.oe_term),
        .sum_all (sum_all),
        .sum_sel (sum_sel),
        .term_en (term_en)
    );

    cell_state_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .sum_all     (sum_all),
        .polarity    (cell_polarity),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .q           (q)
    );

    cell_pad_drive u_drive (
        .ctl       (ctl),
        .sum_sel   (sum_sel),
        .term_en   (term_en),
        .q         (q),
        .polarity  (cell_polarity),
        .push_pull (cell_push_pull),
        .oe_pin_n  (oe_pin_n),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .fb_out    (fb_out)
    );

    assert_off_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_sync && !glb_arch) |-> (!pad_oe && (fb_out == pad_in)));

    assert_plain_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_sync && !glb_arch && !cell_io_sel && cell_push_pull) |-> pad_oe);

    assert_input_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_sync && !glb_arch && cell_io_sel) |-> (!pad_oe && (fb_out == pad_in)));

    assert_open_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cell_push_pull && pad_oe) |-> !pad_out);

    assert_pin_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !glb_sync && glb_arch && !cell_io_sel) |-> pad_out);

    assert_reg_feedback_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_sync && glb_arch && !cell_io_sel) |-> (fb_out == pad_out));

endmodule

// File: tb/pterm_out_cell_bench.sv
module pterm_out_cell_bench;

    localparam int NPT = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NPT-1:0] pt_in = '0;
    logic           glb_sync = 1'b0, glb_arch = 1'b1, cell_io_sel = 1'b0;
    logic           cell_push_pull = 1'b1, cell_polarity = 1'b1;
    logic           oe_pin_n = 1'b0, preload_en = 1'b0, preload_val = 1'b0;
    logic           pad_in = 1'b0;
    logic           pad_out, pad_oe, fb_out;

    int total = 0;
    int bad = 0;
    logic qm = 1'b0;   // bench model of the register
    bit done = 0;

    always #2 clk = ~clk;

    pterm_out_cell #(.NUM_PT(NPT)) u_pterm_out_cell (
        .clk(clk), .rst_n(rst_n), .pt_in(pt_in), .glb_sync(glb_sync),
        .glb_arch(glb_arch), .cell_io_sel(cell_io_sel),
        .cell_push_pull(cell_push_pull), .cell_polarity(cell_polarity),
        .oe_pin_n(oe_pin_n), .preload_en(preload_en), .preload_val(preload_val),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
    );

    function automatic bit is_reg();
        return !glb_sync && glb_arch && !cell_io_sel;
    endfunction

    function automatic bit uses_term();
        return glb_arch && (glb_sync || cell_io_sel);
    endfunction

    function automatic bit exp_level();
        bit s;
        if (is_reg()) return !qm;
        s = uses_term() ? |pt_in[NPT-1:1] : |pt_in;
        return cell_polarity ? s : !s;
    endfunction

    function automatic bit exp_oe();
        bit en;
        if (is_reg())                      en = !oe_pin_n;
        else if (uses_term())              en = pt_in[0];
        else if (glb_sync && !cell_io_sel) en = 1'b1;
        else                               en = 1'b0;
        return en && (cell_push_pull || !exp_level());
    endfunction

    function automatic bit exp_fb();
        return is_reg() ? !qm : pad_in;
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "pad_out", pad_out, exp_level());
        check(tag, "pad_oe",  pad_oe,  exp_oe());
        check(tag, "fb_out",  fb_out,  exp_fb());
    endtask

    // One clock: model the register at the edge, then settle to the falling edge
    task automatic step();
        @(posedge clk);
        if (!rst_n)          qm = 1'b0;
        else if (preload_en) qm = preload_val;
        else                 qm = cell_polarity ? !(|pt_in) : |pt_in;
        @(negedge clk);
    endtask

    task automatic set_mode(input bit s, input bit a, input bit io);
        glb_sync = s; glb_arch = a; cell_io_sel = io;
    endtask

    initial begin
        #(4ns * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        // R11: reset clears register, registered pin reads high for both polarities
        set_mode(0, 1, 0); oe_pin_n = 0; cell_polarity = 0; pt_in = 8'h00;
        step(); step();
        check("R11", "pad_out pol0", pad_out, 1'b1);
        cell_polarity = 1; #1;
        check("R11", "pad_out pol1", pad_out, 1'b1);
        check_all("R11");
        rst_n = 1;

        // R2: full sum captured, including term 0 and the top term
        pt_in = 8'h80; step(); check("R2", "top term", pad_out, 1'b1);
        pt_in = 8'h00; step(); check("R2", "no term", pad_out, 1'b0);
        pt_in = 8'h01; step(); check("R2", "term0 in sum", pad_out, 1'b1);
        oe_pin_n = 1; #1; check("R2", "pin disables", pad_oe, 1'b0);
        // R12: feedback keeps the registered level while disabled
        check("R12", "fb while off", fb_out, 1'b1);
        oe_pin_n = 0;

        // R3: clocked-mode I/O, term 0 only enables
        set_mode(0, 1, 1); pt_in = 8'h01; step();
        check("R3", "level w/o term0", pad_out, 1'b0);
        check("R3", "term0 enable", pad_oe, 1'b1);
        pt_in = 8'h02; step();
        check("R3", "no enable", pad_oe, 1'b0);
        check_all("R3");

        // R4: mixed mode ignores cell_io_sel
        set_mode(1, 1, 0); pt_in = 8'h05; step(); check_all("R4");
        check("R4", "sel0 level", pad_out, 1'b1);
        cell_io_sel = 1; #1;
        check("R4", "sel1 level", pad_out, 1'b1);
        check("R4", "sel1 oe", pad_oe, 1'b1);

        // R5 and R7: plain output, polarity flip
        set_mode(1, 0, 0); pt_in = 8'h01; step();
        check("R5", "level", pad_out, 1'b1);
        check("R5", "always on", pad_oe, 1'b1);
        cell_polarity = 0; #1;
        check("R7", "inverted", pad_out, 1'b0);
        cell_polarity = 1;

        // R6: dedicated input
        set_mode(1, 0, 1); pad_in = 1; step();
        check("R6", "oe off", pad_oe, 1'b0);
        check("R6", "fb=pad_in", fb_out, 1'b1);
        pad_in = 0; #1; check("R6", "fb follows", fb_out, 1'b0);

        // R1: unused mode pair
        set_mode(0, 0, 0); pt_in = 8'hFF; pad_in = 1; step();
        check("R1", "oe off", pad_oe, 1'b0);
        check("R1", "fb=pad_in", fb_out, 1'b1);

        // R8: open-drain releases high, drives low
        set_mode(1, 0, 0); cell_push_pull = 0; pt_in = 8'h10; step();
        check("R8", "high released", pad_oe, 1'b0);
        pt_in = 8'h00; #1; check("R8", "low driven", pad_oe, 1'b1);
        cell_push_pull = 1;

        // R9 and R10: preload against opposing capture value
        set_mode(0, 1, 0); cell_polarity = 1; pt_in = 8'hFF;
        preload_en = 1; preload_val = 1; step();
        check("R9", "pin from preload 1", pad_out, 1'b0);
        check("R10", "fb from preload", fb_out, 1'b0);
        pt_in = 8'h00; preload_val = 0; step();
        check("R9", "pin from preload 0", pad_out, 1'b1);
        preload_en = 0;

        // Random mix over every configuration
        for (int i = 0; i < 3000; i++) begin
            pt_in          = NPT'($urandom);
            glb_sync       = 1'($urandom);
            glb_arch       = 1'($urandom);
            cell_io_sel    = 1'($urandom);
            cell_push_pull = 1'($urandom);
            cell_polarity  = 1'($urandom);
            oe_pin_n       = 1'($urandom);
            pad_in         = 1'($urandom);
            preload_en     = ($urandom % 8) == 0;
            preload_val    = 1'($urandom);
            rst_n          = ($urandom % 64) != 0;
            step();
            check_all("R1 R2 R3 R5 R7 R8 R12 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule